// File: doc/BRIEF.md
# Masked interrupt status controller

This block keeps the interrupt bookkeeping of a storage-card host controller: a raw pending-event register, an enable mask, a card status register, a DMA status register and a global control register. The command and DMA engines report events as single-cycle set pulses. The card-detect logic reports insertion and removal as pulses. The block combines these into one level-sensitive interrupt line. That line is active only while the global interrupt enable is on and at least one pending event is also enabled in the mask.

Software reaches the block through a plain 32-bit register strobe: an address, write data and a write strobe. Read data is combinational from the address, and reads have no side effects. There is no streaming data path, so there is no valid/ready handshake at any edge of the block. Pending bits are cleared by writing ones. The three reset-request bits of the control register do not stay set: a write to them produces a one-cycle request pulse on `ctl_pulse`.

Register map (byte address, `reg_addr[4:2]` selects): 0x00 control, 0x04 mask, 0x08 masked pending view, 0x0C raw pending, 0x10 card status, 0x14 DMA status. Addresses 0x18 and 0x1C are unmapped. `reg_addr[1:0]` is ignored.

Top module: `hostirq_ctrl`

## Requirements
- R1: After reset, control reads 0x0000_0300, card status reads 0x0000_0100, and mask, raw pending, masked pending and DMA status read 0. `irq` and `ctl_pulse` are 0.
- R2: A read of 0x08 returns the raw pending value ANDed with the mask.
- R3: `irq` is 1 exactly when control bit 4 is 1 and (raw pending AND mask) is nonzero. It follows the registers with no added delay.
- R4: A write to 0x08 or to 0x0C clears every raw pending bit written as one and leaves the other bits unchanged.
- R5: A `raw_set` bit sets the matching raw pending bit at the next edge. This holds even if the same bit is cleared by a write in that cycle. `raw_set` bits 31 and 30 are ignored.
- R6: A `card_insert` pulse sets raw bit 30, clears raw bit 31 and sets card status bit 8. A `card_remove` pulse sets raw bit 31, clears raw bit 30 and clears card status bit 8. If both pulses arrive together, insertion wins. A card event overrides a same-cycle software clear of these bits.
- R7: A write to 0x10 clears the card status bits written as one.
- R8: A write to 0x14 clears only DMA status bits 9:0 that are written as one. Bits 31:10 are unaffected by writes. A `dma_set` bit sets its DMA status bit, and the set takes priority over a same-cycle clear.
- R9: A write to 0x00 stores the data with bits 2:0 forced to zero. In the following cycle `ctl_pulse` equals the written bits 2:0. Otherwise `ctl_pulse` is 0.
- R10: A write to 0x04 replaces the mask, and a read returns the mask.
- R11: Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| raw_set | input | 32 | Set pulses for raw pending bits (31:30 ignored) |
| dma_set | input | 32 | Set pulses for DMA status bits |
| card_insert | input | 1 | Card inserted event pulse |
| card_remove | input | 1 | Card removed event pulse |
| ctl_pulse | output | 3 | One-cycle reset requests from control bits 2:0 |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions check the following properties on every cycle:
- set-over-clear priority and write-one-to-clear in each status register;
- that DMA status bits above 9 are immune to writes;
- that the two card bits are never both set;
- that the interrupt stays low without the global enable;
- that the masked view never shows a masked-off bit;
- that a control pulse always follows a control write.

Some behaviours are shown only by the bench's scenarios: the exact register values, the simultaneous insert/remove tie, unmapped-address behaviour, and the full interrupt equation. For these, a behavioural model is compared against the read data, the interrupt and the pulse outputs on every clock, under both directed and random register traffic.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;
  localparam int DATA_W = 32;

  // word indices of the register map (byte address bits [4:2])
  localparam int IDX_CTL     = 0;
  localparam int IDX_MASK    = 1;
  localparam int IDX_PEND_M  = 2;
  localparam int IDX_PEND    = 3;
  localparam int IDX_CARD_ST = 4;
  localparam int IDX_DMA_ST  = 5;

  // bit positions the block's behaviour depends on
  localparam int IRQ_EN_BIT   = 4;
  localparam int CARD_IN_BIT  = 30;
  localparam int CARD_OUT_BIT = 31;
  localparam int PRESENT_BIT  = 8;
endpackage

// File: rtl/hostirq_ctl_reg.sv
module hostirq_ctl_reg #(
  parameter int DW = 32,
  parameter int PULSE_W = 3,
  parameter logic [DW-1:0] RST_VAL = 32'h0000_0300
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      q_o,
  output logic [PULSE_W-1:0] pulse_o
);
  localparam logic [DW-1:0] PULSE_MASK = DW'((64'd1 << PULSE_W) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= RST_VAL & ~PULSE_MASK;
      pulse_o <= '0;
    end else begin
      if (wr_i) q_o <= wdata_i & ~PULSE_MASK;
      pulse_o <= wr_i ? wdata_i[PULSE_W-1:0] : '0;
    end
  end

  // a request pulse only ever follows a control write
  p_pulse_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o != '0) |-> $past(wr_i))
    else $error("ctl pulse without write");
endmodule

// File: rtl/hostirq_w1c_reg.sv
module hostirq_w1c_reg #(
  parameter int DW = 32,
  parameter logic [DW-1:0] RST_VAL  = '0,
  parameter logic [DW-1:0] W1C_MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] hwclr_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] sw_clr;
  logic [DW-1:0] nxt;

  always_comb begin
    sw_clr = wr_i ? (wdata_i & W1C_MASK) : '0;
    // hardware clear beats hardware set beats software clear
    nxt = ((q_o & ~sw_clr) | set_i) & ~hwclr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= nxt;
  end

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & ~hwclr_i) != '0) |=>
      ((q_o & $past(set_i & ~hwclr_i)) == $past(set_i & ~hwclr_i)))
    else $error("set pulse lost");

  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o & $past(wdata_i & W1C_MASK & ~set_i)) == '0))
    else $error("write-one-to-clear failed");

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && set_i == '0 && hwclr_i == '0) |=>
      ((q_o & ~W1C_MASK) == $past(q_o & ~W1C_MASK)))
    else $error("protected bits changed by write");
endmodule

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl
  import hostirq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int PULSE_W   = 3,
  parameter int DMA_W1C_W = 10,
  parameter logic [DATA_W-1:0] CTL_RST  = 32'h0000_0300,
  parameter logic [DATA_W-1:0] STAT_RST = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       raw_set,
  input  logic [31:0]       dma_set,
  input  logic              card_insert,
  input  logic              card_remove,
  output logic [PULSE_W-1:0] ctl_pulse,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] IN_HOT   = DATA_W'(1) << CARD_IN_BIT;
  localparam logic [DATA_W-1:0] OUT_HOT  = DATA_W'(1) << CARD_OUT_BIT;
  localparam logic [DATA_W-1:0] PRES_HOT = DATA_W'(1) << PRESENT_BIT;
  localparam logic [DATA_W-1:0] DMA_CLR_MASK = DATA_W'((64'd1 << DMA_W1C_W) - 1);

  logic [IDX_W-1:0]  idx;
  logic              unused_addr_lsb;
  logic              wr_ctl, wr_mask, wr_pend, wr_card, wr_dma;
  logic              ev_in, ev_out;
  logic [DATA_W-1:0] pend_set, pend_hwclr, card_set, card_hwclr;
  logic [DATA_W-1:0] ctl_q, mask_q, pend_q, card_q, dma_q;

  assign idx             = reg_addr[ADDR_W-1:2];
  assign unused_addr_lsb = &{1'b0, reg_addr[1:0]};

  assign wr_ctl  = reg_wr && (idx == IDX_W'(IDX_CTL));
  assign wr_mask = reg_wr && (idx == IDX_W'(IDX_MASK));
  assign wr_pend = reg_wr && ((idx == IDX_W'(IDX_PEND_M)) || (idx == IDX_W'(IDX_PEND)));
  assign wr_card = reg_wr && (idx == IDX_W'(IDX_CARD_ST));
  assign wr_dma  = reg_wr && (idx == IDX_W'(IDX_DMA_ST));

  // insertion wins a tie so the two presence events stay exclusive
  assign ev_in  = card_insert;
  assign ev_out = card_remove & ~card_insert;

  always_comb begin
    pend_set   = (raw_set & ~(IN_HOT | OUT_HOT))
               | (ev_in ? IN_HOT : '0) | (ev_out ? OUT_HOT : '0);
    pend_hwclr = (ev_in ? OUT_HOT : '0) | (ev_out ? IN_HOT : '0);
    card_set   = ev_in  ? PRES_HOT : '0;
    card_hwclr = ev_out ? PRES_HOT : '0;
  end

  hostirq_ctl_reg #(.DW(DATA_W), .PULSE_W(PULSE_W), .RST_VAL(CTL_RST)) u_ctl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_ctl), .wdata_i(reg_wdata),
    .q_o(ctl_q), .pulse_o(ctl_pulse)
  );

  hostirq_w1c_reg #(.DW(DATA_W), .RST_VAL('0), .W1C_MASK('1)) u_pend (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_pend), .wdata_i(reg_wdata),
    .set_i(pend_set), .hwclr_i(pend_hwclr), .q_o(pend_q)
  );

  hostirq_w1c_reg #(.DW(DATA_W), .RST_VAL(STAT_RST), .W1C_MASK('1)) u_card (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_card), .wdata_i(reg_wdata),
    .set_i(card_set), .hwclr_i(card_hwclr), .q_o(card_q)
  );

  hostirq_w1c_reg #(.DW(DATA_W), .RST_VAL('0), .W1C_MASK(DMA_CLR_MASK)) u_dma (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_dma), .wdata_i(reg_wdata),
    .set_i(dma_set), .hwclr_i('0), .q_o(dma_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;
  end

  always_comb begin
    case (idx)
      IDX_W'(IDX_CTL):     reg_rdata = ctl_q;
      IDX_W'(IDX_MASK):    reg_rdata = mask_q;
      IDX_W'(IDX_PEND_M):  reg_rdata = pend_q & mask_q;
      IDX_W'(IDX_PEND):    reg_rdata = pend_q;
      IDX_W'(IDX_CARD_ST): reg_rdata = card_q;
      IDX_W'(IDX_DMA_ST):  reg_rdata = dma_q;
      default:             reg_rdata = '0;
    endcase
  end

  assign irq = ctl_q[IRQ_EN_BIT] & (|(pend_q & mask_q));

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[IRQ_EN_BIT] |-> !irq)
    else $error("irq without global enable");

  p_card_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q[CARD_IN_BIT] && pend_q[CARD_OUT_BIT]))
    else $error("both card events pending");

  p_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    card_insert |=> (card_q[PRESENT_BIT] && pend_q[CARD_IN_BIT]))
    else $error("insert not recorded");

  p_masked_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_W'(IDX_PEND_M)) |-> ((reg_rdata & ~mask_q) == '0))
    else $error("masked view leaks disabled bit");
endmodule

// File: tb/hostirq_ctrl_test.sv
module hostirq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] raw_set = '0;
  logic [31:0] dma_set = '0;
  logic        card_insert = 1'b0;
  logic        card_remove = 1'b0;
  logic [2:0]  ctl_pulse;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] m_ctl = 32'h300, m_mask = 0, m_pend = 0, m_card = 32'h100, m_dma = 0;
  logic [2:0]  m_pulse = 0;

  always #4 clk = ~clk;

  hostirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_set(raw_set),
    .dma_set(dma_set), .card_insert(card_insert), .card_remove(card_remove),
    .ctl_pulse(ctl_pulse), .irq(irq)
  );

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a[4:2])
      3'd0: return m_ctl;
      3'd1: return m_mask;
      3'd2: return m_pend & m_mask;
      3'd3: return m_pend;
      3'd4: return m_card;
      3'd5: return m_dma;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [4:0] a);
    case (a[4:2])
      3'd0: return "R9";
      3'd1: return "R10";
      3'd2: return "R2";
      3'd3: return "R4";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%08h expected=%08h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive at the falling edge, compare, then advance model at the rising edge
  task automatic step(input logic wr, input logic [4:0] a, input logic [31:0] wd,
                      input logic [31:0] rs, input logic [31:0] ds,
                      input logic ci, input logic cr, input string tag);
    string t;
    logic exp_irq;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; raw_set = rs; dma_set = ds;
    card_insert = ci; card_remove = cr;
    #1;
    t = (tag != "") ? tag : addr_tag(a);
    check(t, "rdata", reg_rdata, m_read(a));
    exp_irq = m_ctl[4] && ((m_pend & m_mask) != 0);
    check("R3", "irq", {31'b0, irq}, {31'b0, exp_irq});
    check("R9", "ctl_pulse", {29'b0, ctl_pulse}, {29'b0, m_pulse});
    @(posedge clk);
    m_pulse = (wr && a[4:2] == 3'd0) ? wd[2:0] : 3'd0;
    if (wr) case (a[4:2])
      3'd0: m_ctl = wd & ~32'h7;
      3'd1: m_mask = wd;
      3'd2, 3'd3: m_pend = m_pend & ~wd;
      3'd4: m_card = m_card & ~wd;
      3'd5: m_dma = m_dma & ~(wd & 32'h3FF);
      default: ;
    endcase
    m_pend = m_pend | (rs & 32'h3FFF_FFFF);
    m_dma  = m_dma | ds;
    if (ci) begin
      m_pend[30] = 1'b1; m_pend[31] = 1'b0; m_card[8] = 1'b1;
    end else if (cr) begin
      m_pend[31] = 1'b1; m_pend[30] = 1'b0; m_card[8] = 1'b0;
    end
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(1'b0, a, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic wrr(input logic [4:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 32'h0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every address after reset
    for (int i = 0; i < 8; i++) rd(5'(i * 4), "R1");

    // R10: mask write and readback
    wrr(5'h04, 32'h4000_0F0F, "R10");
    rd(5'h04, "R10");

    // R5: set pulse and software clear of the same bits in one cycle
    step(1'b1, 5'h0C, 32'h0000_0F00, 32'hC000_0F03, 32'h0, 1'b0, 1'b0, "R5");
    rd(5'h0C, "R5");
    rd(5'h08, "R2");

    // R3: interrupt off until global enable, R9: pulse bits
    wrr(5'h00, 32'h0000_0317, "R9");
    rd(5'h00, "R9");
    rd(5'h08, "R3");

    // R4: clear through the masked address, then the raw address
    wrr(5'h08, 32'h0000_0003, "R4");
    rd(5'h0C, "R4");
    wrr(5'h0C, 32'h0000_0F00, "R4");
    rd(5'h0C, "R4");

    // R6: card events, tie, and event versus software clear
    step(1'b0, 5'h0C, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, "R6");
    rd(5'h10, "R6");
    rd(5'h0C, "R6");
    step(1'b0, 5'h0C, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, "R6");
    rd(5'h10, "R6");
    step(1'b1, 5'h0C, 32'hC000_0000, 32'h0, 32'h0, 1'b1, 1'b1, "R6");
    rd(5'h0C, "R6");
    rd(5'h10, "R6");

    // R7: status clear
    wrr(5'h10, 32'h0000_0100, "R7");
    rd(5'h10, "R7");

    // R8: upper DMA bits immune, set beats clear
    step(1'b0, 5'h14, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8");
    wrr(5'h14, 32'hFFFF_FFFF, "R8");
    rd(5'h14, "R8");
    step(1'b1, 5'h14, 32'h0000_0003, 32'h0, 32'h0000_0001, 1'b0, 1'b0, "R8");
    rd(5'h14, "R8");

    // R11: unmapped addresses
    wrr(5'h18, 32'hFFFF_FFFF, "R11");
    wrr(5'h1C, 32'hFFFF_FFFF, "R11");
    for (int i = 0; i < 8; i++) rd(5'(i * 4), "R11");

    // mixed random traffic, every output compared each cycle
    for (int n = 0; n < 4000; n++) begin
      logic w;
      logic [31:0] d, rs, ds;
      w  = ($urandom % 2) == 0;
      d  = $urandom;
      rs = $urandom & $urandom & $urandom & $urandom;
      ds = $urandom & $urandom & $urandom & $urandom;
      step(w, 5'($urandom), d, rs, ds, ($urandom % 16) == 0, ($urandom % 16) == 0, "");
    end

    summary();
  end
endmodule